// File: doc/BRIEF.md
# Trigger-Sequenced Waveform Controller

This block is the control sequencer for a multi-channel sine pattern generator. It does not compute samples. It drives three control lines that all sine channels share: a clock-enable, a configuration write-enable and a synchronous clear. The clear also pulls every channel back to its programmed starting phase. The block also exports a 3-bit code for its current state and a ready flag, which downstream logic uses to know when the waveforms are valid.

An operating cycle runs as follows. While the sequencer is parked, software may load frequency and phase values by holding the config request. A start request arms the generator and clears the channels. The sequencer then waits for an external trigger, which repeats at about one millisecond. Every rising edge of the trigger causes a one-cycle phase realignment, after which the sequencer runs. This applies to the first trigger and to every later one. A stop request ends the iteration and parks the sequencer again. The trigger comes from outside the clock domain, so it passes through a parameterised synchronizer and an edge detector before the state machine sees it.

Top module: `gseq_ctrl`

## Requirements
- R1: State codes on `state_o` are Idle 3'b000, Config 3'b001, Wait 3'b010, Phase-reset 3'b011 and Run 3'b100. After reset the state is Idle and `ce_o`, `we_o`, `sclr_o` and `ready_o` are all low.
- R2: In Idle, `ce_o` is low. When `cfg_i` is high at a clock edge in Idle, the next state is Config. This holds even if `start_i` is also high.
- R3: In Config, `we_o` and `ce_o` are high. When `cfg_i` drops, the state returns to Idle on the next edge.
- R4: When `start_i` is high and `cfg_i` is low in Idle, the next state is Wait with `ce_o` high. `sclr_o` is high for the first Wait cycle only.
- R5: A rising edge on `trig_i` that is set up before clock edge k puts the state in Phase-reset after edge k+SYNC_STAGES. The state stays there for one cycle with `sclr_o` and `ce_o` high, and then moves to Run.
- R6: A new rising trigger edge while in Run sends the state back through one Phase-reset cycle and then returns it to Run.
- R7: When `stop_i` is high in any state other than Idle, the next state is Idle. Stop wins over a trigger edge that arrives in the same cycle.
- R8: Holding `trig_i` high for many cycles produces exactly one Phase-reset cycle.
- R9: `ready_o` is high only in Run.
- R10: `start_i` and `cfg_i` have no effect outside Idle. The state and `we_o` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arm request (acted on in Idle only) |
| stop_i | input | 1 | End current iteration |
| cfg_i | input | 1 | Configuration load request (acted on in Idle only) |
| trig_i | input | 1 | Asynchronous trigger, rising edge significant |
| ce_o | output | 1 | Clock-enable to the sine channels |
| we_o | output | 1 | Configuration write-enable to the sine channels |
| sclr_o | output | 1 | Synchronous clear / phase realign to the sine channels |
| state_o | output | 3 | Current state code |
| ready_o | output | 1 | Waveforms valid (Run only) |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default of 2. This moves trigger recognition to the fourth clock edge after the input rises, which exposes any hidden one-cycle assumption in the synchronizer chain. The longer chain also leaves a window of several cycles in which a stop request can be placed on the exact cycle the trigger edge reaches the state machine. That is the window needed to show that stop wins over a trigger. Held triggers and re-triggers during Run are driven through the same chain.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'b000,
        ST_CFG   = 3'b001,
        ST_WAIT  = 3'b010,
        ST_PHRST = 3'b011,
        ST_RUN   = 3'b100
    } gseq_state_e;

    typedef struct packed {
        logic ce;
        logic we;
        logic sclr;
        logic ready;
    } gseq_ctl_t;

    function automatic logic state_enabled(gseq_state_e s);
        return (s != ST_IDLE);
    endfunction

    function automatic gseq_ctl_t ctl_decode(gseq_state_e s, logic clr_pend);
        gseq_ctl_t c;
        c.ce    = state_enabled(s);
        c.we    = (s == ST_CFG);
        c.sclr  = clr_pend;
        c.ready = (s == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/gseq_trig_sync.sv
module gseq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                sh_q[i] <= sh_q[i-1];
            end
            prev_q <= sh_q[LAST];
        end
    end

    assign rise_o = sh_q[LAST] & ~prev_q;

endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
    import gseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        stop_i,
    input  logic        cfg_i,
    input  logic        trig_rise,
    output gseq_state_e state_q,
    output logic        clr_q
);
    gseq_state_e nxt;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_i)        nxt = ST_CFG;
                else if (start_i) nxt = ST_WAIT;
            end
            ST_CFG: begin
                if (stop_i || !cfg_i) nxt = ST_IDLE;
            end
            ST_WAIT: begin
                if (stop_i)         nxt = ST_IDLE;
                else if (trig_rise) nxt = ST_PHRST;
            end
            ST_PHRST: begin
                nxt = stop_i ? ST_IDLE : ST_RUN;
            end
            ST_RUN: begin
                if (stop_i)         nxt = ST_IDLE;
                else if (trig_rise) nxt = ST_PHRST;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            clr_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            clr_q   <= (nxt == ST_PHRST) ||
                       (state_q == ST_IDLE && nxt == ST_WAIT);
        end
    end

endmodule

// File: rtl/gseq_outdec.sv
module gseq_outdec
    import gseq_pkg::*;
(
    input  gseq_state_e state_i,
    input  logic        clr_i,
    output gseq_ctl_t   ctl_o
);
    always_comb begin
        ctl_o = ctl_decode(state_i, clr_i);
    end

endmodule

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
    import gseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       cfg_i,
    input  logic       trig_i,
    output logic       ce_o,
    output logic       we_o,
    output logic       sclr_o,
    output logic [2:0] state_o,
    output logic       ready_o
);
    logic        trig_rise;
    gseq_state_e st;
    logic        clr;
    gseq_ctl_t   ctl;

    gseq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .din    (trig_i),
        .rise_o (trig_rise)
    );

    gseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .cfg_i     (cfg_i),
        .trig_rise (trig_rise),
        .state_q   (st),
        .clr_q     (clr)
    );

    gseq_outdec u_dec (
        .state_i (st),
        .clr_i   (clr),
        .ctl_o   (ctl)
    );

    assign ce_o    = ctl.ce;
    assign we_o    = ctl.we;
    assign sclr_o  = ctl.sclr;
    assign ready_o = ctl.ready;
    assign state_o = st;

endmodule

// File: rtl/gseq_chk.sv
module gseq_chk
    import gseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       stop_i,
    input logic       cfg_i,
    input logic       ce_o,
    input logic       we_o,
    input logic       sclr_o,
    input logic [2:0] state_o,
    input logic       ready_o
);
    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
        state_o inside {ST_IDLE, ST_CFG, ST_WAIT, ST_PHRST, ST_RUN});

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE) |-> (!ce_o && !we_o));

    p_we_from_cfg_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(we_o) |-> $past(cfg_i));

    p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_IDLE && start_i && !cfg_i) |=> (state_o == ST_WAIT && sclr_o && ce_o));

    p_phrst_ctl_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_PHRST) |-> (sclr_o && ce_o));

    p_phrst_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_PHRST && !stop_i) |=> (state_o == ST_RUN));

    p_stop_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_i && state_o != ST_IDLE) |=> (state_o == ST_IDLE));

    p_single_phrst_r8: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_PHRST) |=> (state_o != ST_PHRST));

    p_ready_run_r9: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (state_o == ST_RUN));

    p_no_cfg_late_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o inside {ST_WAIT, ST_PHRST, ST_RUN}) |=> (state_o != ST_CFG));

endmodule

bind gseq_ctrl gseq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .cfg_i   (cfg_i),
    .ce_o    (ce_o),
    .we_o    (we_o),
    .sclr_o  (sclr_o),
    .state_o (state_o),
    .ready_o (ready_o)
);

// File: tb/sim_gseq_ctrl.sv
`timescale 1ns/1ps
module sim_gseq_ctrl;
    localparam int SYNC = 3;
    localparam int LAT  = SYNC + 1;

    localparam logic [2:0] S_IDLE = 3'b000, S_CFG = 3'b001, S_WAIT = 3'b010,
                           S_PHR  = 3'b011, S_RUN = 3'b100;

    logic clk = 1'b0, rst = 1'b1;
    logic start_i = 0, stop_i = 0, cfg_i = 0, trig_i = 0;
    logic ce_o, we_o, sclr_o, ready_o;
    logic [2:0] state_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gseq_ctrl #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
        .cfg_i(cfg_i), .trig_i(trig_i), .ce_o(ce_o), .we_o(we_o),
        .sclr_o(sclr_o), .state_o(state_o), .ready_o(ready_o)
    );

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [2:0] st, logic ce, logic we, logic cl, logic rd);
        chk(req, "state", state_o, st);
        chk(req, "ce",    ce_o, ce);
        chk(req, "we",    we_o, we);
        chk(req, "sclr",  sclr_o, cl);
        chk(req, "ready", ready_o, rd);
    endtask

    task automatic t_reset();
        rst = 1; tick(3);
        chk_out("R1", S_IDLE, 0, 0, 0, 0);
        rst = 0; tick(2);
        chk_out("R1", S_IDLE, 0, 0, 0, 0);
    endtask

    task automatic t_config();
        cfg_i = 1; start_i = 1; tick();
        chk_out("R2", S_CFG, 1, 1, 0, 0);
        start_i = 0; tick(2);
        chk_out("R3", S_CFG, 1, 1, 0, 0);
        cfg_i = 0; tick();
        chk_out("R3", S_IDLE, 0, 0, 0, 0);
    endtask

    task automatic t_start();
        start_i = 1; tick();
        chk_out("R4", S_WAIT, 1, 0, 1, 0);
        start_i = 0; tick();
        chk_out("R4", S_WAIT, 1, 0, 0, 0);
        cfg_i = 1; start_i = 1; tick();
        chk_out("R10", S_WAIT, 1, 0, 0, 0);
        cfg_i = 0; start_i = 0; tick();
    endtask

    task automatic t_first_trigger();
        int phr = 0;
        trig_i = 1; tick(LAT - 1);
        chk_out("R5", S_WAIT, 1, 0, 0, 0);
        tick();
        chk_out("R5", S_PHR, 1, 0, 1, 0);
        tick();
        chk_out("R5", S_RUN, 1, 0, 0, 1);
        for (int i = 0; i < 12; i++) begin
            tick();
            if (state_o == S_PHR) phr++;
        end
        chk("R8", "extra phase-reset cycles", phr, 0);
        chk("R9", "ready held in run", ready_o, 1);
        trig_i = 0; tick(LAT + 1);
    endtask

    task automatic t_retrigger();
        trig_i = 1; tick(LAT - 1);
        chk_out("R6", S_RUN, 1, 0, 0, 1);
        tick();
        chk_out("R6", S_PHR, 1, 0, 1, 0);
        tick();
        chk_out("R6", S_RUN, 1, 0, 0, 1);
        start_i = 1; cfg_i = 1; tick();
        chk_out("R10", S_RUN, 1, 0, 0, 1);
        start_i = 0; cfg_i = 0;
        trig_i = 0; tick(LAT + 1);
    endtask

    task automatic t_stop_beats_trigger();
        trig_i = 1; tick(LAT - 1);
        stop_i = 1; tick();
        chk_out("R7", S_IDLE, 0, 0, 0, 0);
        stop_i = 0; tick(3);
        chk_out("R7", S_IDLE, 0, 0, 0, 0);
        trig_i = 0; tick(LAT + 1);
    endtask

    task automatic t_stop_other_states();
        start_i = 1; tick(); start_i = 0;
        stop_i = 1; tick(); stop_i = 0;
        chk("R7", "stop from wait", state_o, S_IDLE);
        cfg_i = 1; tick();
        stop_i = 1; tick(); stop_i = 0; cfg_i = 0;
        chk("R7", "stop from config", state_o, S_IDLE);
        start_i = 1; tick(); start_i = 0;
        trig_i = 1; tick(LAT);
        chk("R5", "phase-reset before stop", state_o, S_PHR);
        stop_i = 1; tick(); stop_i = 0;
        chk_out("R7", S_IDLE, 0, 0, 0, 0);
        trig_i = 0; tick(LAT + 1);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_config();
        t_start();
        t_first_trigger();
        t_retrigger();
        t_stop_beats_trigger();
        t_stop_other_states();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule